// File: doc/BRIEF.md
# Interrupt Redirection Controller with Message Output

This block turns pin service requests into message-signalled interrupts. Software programs it through a two-register window. A select register names one internal register. A data window then reads or writes the register that was named. The internal registers are an identification register, a fixed version register and a redirection table that holds one 64-bit entry for each input pin. Each entry is reached as two 32-bit halves.

A requester presents a pin number with a valid strobe. The block then looks up that pin's entry. An entry that is unmasked, edge-triggered and uses physical destination produces one address/data message on a valid/ready output. Any other entry, and any pin beyond the table, is dropped without a message. Requests are handled one at a time. A new one is taken only after the pending message has been handed off.

The bus read path is combinational: `bus_rdata` reflects the current request in the same cycle. Writes take effect at the clock edge. Reset is asserted asynchronously and released through a two-stage synchronizer, so the block is usable from the third clock edge after `rst_n` rises.

Top module: `irq_route_msi`

## Requirements
- R1: A bus access whose `bus_size` is not 4 (bytes) reads as zero, and a write of that kind changes no register.
- R2: Offset 0x00 holds the 8-bit select value, which is written from `bus_wdata[7:0]` and reads back zero-extended. Offset 0x10 is the data window. Every other offset reads zero and ignores writes.
- R3: The identification word is read through select 0x00 and through select 0x02. A window write through select 0x00 updates only bits 27:24 and leaves every other bit at zero. A write through select 0x02 changes nothing.
- R4: Select 0x01 reads the constant 0x00170020: bits 23:16 hold the last entry index (23) and bits 7:0 hold the version code 0x20. A write through select 0x01 has no effect.
- R5: Selects 0x10 to 0x3F reach the table. The pin is (select − 0x10) >> 1. An even select reaches entry bits 31:0 and an odd select reaches bits 63:32. Writing one half leaves the other half unchanged.
- R6: A window access with select 0x03 to 0x0F or 0x40 to 0xFF reads zero and changes no register.
- R7: After reset the select is 0, the identification word is 0, every entry is 0x0000_0000_0001_0000 (mask set), no message is pending and `svc_ready` is 1.
- R8: A serviced pin produces no message when its entry has the mask bit 16 set, the destination-mode bit 11 set, or the trigger bit 15 set, or when the pin number is 24 or greater.
- R9: The message address is 0xFEE0_0000 with entry bits 63:56 placed in address bits 19:12 and entry bits 55:49 placed in address bits 11:5.
- R10: The message data is entry bits 7:0 in data bits 7:0 and entry bits 10:8 in data bits 10:8. All other data bits, including the assert bit 14 and the trigger bit 15, are zero.
- R11: `msg_valid` rises in the cycle after a request is accepted. Address and data then stay stable until `msg_ready` is seen. `svc_ready` is low while a message is pending, and a request presented at that time is not taken.
- R12: When a window write to an entry and a service request for that pin fall in the same cycle, the message is built from the entry as it was before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset in the window |
| bus_size | input | 4 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current access |
| svc_valid | input | 1 | Pin service request |
| svc_pin | input | 5 | Pin to service |
| svc_ready | output | 1 | A request can be taken |
| msg_valid | output | 1 | Message pending |
| msg_ready | input | 1 | Message taken by the sink |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |

## Verification
A window write that rewrites a table entry and a service request for that same pin can land on one clock edge. The bench provokes this on purpose. It first programs a pin with an eligible vector. Then, in a single cycle, it drives a write that masks the pin and changes its vector, together with a request for that pin. The message that comes out must carry the old vector. A follow-up request must then be dropped, and a readback must show the new half written in full.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int unsigned F_VEC_LO  = 0;
  localparam int unsigned F_DLV_LO  = 8;
  localparam int unsigned F_DSTMODE = 11;
  localparam int unsigned F_TRIG    = 15;
  localparam int unsigned F_MASK    = 16;
  localparam int unsigned F_XDST_LO = 49;
  localparam int unsigned F_DST_LO  = 56;

  localparam logic [31:0] MSI_BASE  = 32'hFEE0_0000;
  localparam logic [63:0] ENTRY_RST = 64'h0000_0000_0001_0000;

  typedef struct packed {
    logic        ok;
    logic [31:0] addr;
    logic [31:0] data;
  } msi_msg_t;
endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs #(
  parameter int unsigned NUM_PINS = 24,
  parameter int unsigned VER_CODE = 32'h20,
  parameter int unsigned AW       = 8,
  parameter int unsigned SEL_W    = 8,
  parameter int unsigned OFS_SEL  = 0,
  parameter int unsigned OFS_WIN  = 16,
  parameter int unsigned IDX_ID   = 0,
  parameter int unsigned IDX_VER  = 1,
  parameter int unsigned IDX_ARB  = 2,
  parameter int unsigned IDX_TBL  = 16,
  localparam int unsigned PIN_W   = $clog2(NUM_PINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_req,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [3:0]       bus_size,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [PIN_W-1:0] lk_pin,
  output logic             lk_hit,
  output logic [63:0]      lk_entry
);
  import irq_route_pkg::*;

  localparam logic [SEL_W-1:0] TBL_LO  = SEL_W'(IDX_TBL);
  localparam logic [SEL_W-1:0] TBL_HI  = SEL_W'(IDX_TBL + 2 * NUM_PINS - 1);
  localparam logic [31:0]      ID_MASK = 32'h0F00_0000;
  localparam logic [31:0]      VER_WORD = {8'h00, 8'(NUM_PINS - 1), 8'h00, 8'(VER_CODE)};

  logic [SEL_W-1:0] sel_q, sel_d;
  logic [31:0]      id_q, id_d;
  logic             sel_en, id_en;
  logic [63:0]      tbl_q [NUM_PINS];

  logic             full, hit_sel, hit_win, win_wr, tbl_hit;
  logic [SEL_W-1:0] tbl_off;
  logic [PIN_W-1:0] tbl_pin;
  logic [31:0]      win_rd;
  logic             unused_off;

  always_comb begin
    full    = (bus_size == 4'd4);
    hit_sel = bus_req && full && (bus_addr == AW'(OFS_SEL));
    hit_win = bus_req && full && (bus_addr == AW'(OFS_WIN));
    win_wr  = hit_win && bus_we;
    tbl_hit = (sel_q >= TBL_LO) && (sel_q <= TBL_HI);
    tbl_off = sel_q - TBL_LO;
    tbl_pin = tbl_off[PIN_W:1];
  end
  assign unused_off = ^tbl_off[SEL_W-1:PIN_W+1];

  // window read mux
  always_comb begin
    win_rd = '0;
    if (tbl_hit) begin
      win_rd = tbl_off[0] ? tbl_q[tbl_pin][63:32] : tbl_q[tbl_pin][31:0];
    end else if (sel_q == SEL_W'(IDX_ID) || sel_q == SEL_W'(IDX_ARB)) begin
      win_rd = id_q;
    end else if (sel_q == SEL_W'(IDX_VER)) begin
      win_rd = VER_WORD;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_sel && !bus_we)      bus_rdata = {{(32-SEL_W){1'b0}}, sel_q};
    else if (hit_win && !bus_we) bus_rdata = win_rd;
  end

  // next state of select and id
  always_comb begin
    sel_en = hit_sel && bus_we;
    sel_d  = bus_wdata[SEL_W-1:0];
    id_en  = win_wr && (sel_q == SEL_W'(IDX_ID));
    id_d   = bus_wdata & ID_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      id_q  <= '0;
    end else begin
      if (sel_en) sel_q <= sel_d;
      if (id_en)  id_q  <= id_d;
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_ent
    logic        wr_lo, wr_hi;
    logic [63:0] nxt;
    always_comb begin
      wr_lo = win_wr && tbl_hit && (tbl_pin == PIN_W'(i)) && !tbl_off[0];
      wr_hi = win_wr && tbl_hit && (tbl_pin == PIN_W'(i)) &&  tbl_off[0];
      nxt   = tbl_q[i];
      if (wr_lo) nxt[31:0]  = bus_wdata;
      if (wr_hi) nxt[63:32] = bus_wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            tbl_q[i] <= ENTRY_RST;
      else if (wr_lo || wr_hi) tbl_q[i] <= nxt;
    end
  end

  // service lookup port
  always_comb begin
    lk_hit   = (32'(lk_pin) < NUM_PINS);
    lk_entry = lk_hit ? tbl_q[lk_pin] : '0;
  end

  AST_NARROW_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_size != 4'd4) |=> ($stable(sel_q) && $stable(id_q))); // R1
  AST_ID_FIELD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (id_q & ~ID_MASK) == 32'h0); // R3
  AST_ARB_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr && sel_q == SEL_W'(IDX_ARB)) |=> $stable(id_q)); // R3
endmodule

// File: rtl/irq_route_fmt.sv
module irq_route_fmt (
  input  logic                      hit,
  input  logic [63:0]               entry,
  output irq_route_pkg::msi_msg_t   msg
);
  import irq_route_pkg::*;

  logic unused_bits;
  assign unused_bits = ^{entry[48:17], entry[14:12]};

  always_comb begin
    msg.ok   = hit && !entry[F_MASK] && !entry[F_DSTMODE] && !entry[F_TRIG];
    msg.addr = MSI_BASE | {12'h000, entry[F_DST_LO +: 8], entry[F_XDST_LO +: 7], 5'b0};
    msg.data = {16'h0000, entry[F_TRIG], 1'b0, 3'b000,
                entry[F_DLV_LO +: 3], entry[F_VEC_LO +: 8]};
  end
endmodule

// File: rtl/irq_route_svc.sv
module irq_route_svc (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    svc_valid,
  output logic                    svc_ready,
  input  irq_route_pkg::msi_msg_t fmt_msg,
  output logic                    msg_valid,
  input  logic                    msg_ready,
  output logic [31:0]             msg_addr,
  output logic [31:0]             msg_data
);
  logic        vld_q, vld_d;
  logic [31:0] addr_q, data_q;
  logic        accept, load;

  always_comb begin
    accept = svc_valid && !vld_q;
    load   = accept && fmt_msg.ok;
    vld_d  = vld_q;
    if (load)                   vld_d = 1'b1;
    else if (vld_q && msg_ready) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (load) begin
        addr_q <= fmt_msg.addr;
        data_q <= fmt_msg.data;
      end
    end
  end

  assign svc_ready = !vld_q;
  assign msg_valid = vld_q;
  assign msg_addr  = addr_q;
  assign msg_data  = data_q;

  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data))); // R11
  AST_DROP_INELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !fmt_msg.ok) |=> !msg_valid); // R8
  AST_ADDR_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_addr[31:20] == 12'hFEE && msg_addr[4:0] == 5'd0)); // R9
  AST_DATA_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_data[31:11] == 21'd0)); // R10
endmodule

// File: rtl/irq_route_msi.sv
module irq_route_msi #(
  parameter int unsigned NUM_PINS = 24,
  parameter int unsigned VER_CODE = 32'h20,
  localparam int unsigned PIN_W   = $clog2(NUM_PINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_req,
  input  logic             bus_we,
  input  logic [7:0]       bus_addr,
  input  logic [3:0]       bus_size,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             svc_valid,
  input  logic [PIN_W-1:0] svc_pin,
  output logic             svc_ready,
  output logic             msg_valid,
  input  logic             msg_ready,
  output logic [31:0]      msg_addr,
  output logic [31:0]      msg_data
);
  import irq_route_pkg::*;

  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  logic        lk_hit;
  logic [63:0] lk_entry;
  msi_msg_t    fmt_msg;

  irq_route_regs #(.NUM_PINS(NUM_PINS), .VER_CODE(VER_CODE)) u_regs (
    .clk(clk), .rst_n(rst_n_i),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lk_pin(svc_pin), .lk_hit(lk_hit), .lk_entry(lk_entry)
  );

  irq_route_fmt u_fmt (.hit(lk_hit), .entry(lk_entry), .msg(fmt_msg));

  irq_route_svc u_svc (
    .clk(clk), .rst_n(rst_n_i),
    .svc_valid(svc_valid), .svc_ready(svc_ready), .fmt_msg(fmt_msg),
    .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );
endmodule

// File: tb/sim_irq_route_msi.sv
module sim_irq_route_msi;
  logic clk = 1'b0;
  logic rst_n;
  logic bus_req, bus_we;
  logic [7:0] bus_addr;
  logic [3:0] bus_size;
  logic [31:0] bus_wdata, bus_rdata;
  logic svc_valid, svc_ready, msg_valid, msg_ready;
  logic [4:0] svc_pin;
  logic [31:0] msg_addr, msg_data;

  int checks = 0;
  int fails  = 0;

  logic [63:0] m_tbl [24];
  logic [7:0]  m_sel;
  logic [31:0] m_id;

  always #5 clk = ~clk;

  irq_route_msi u0 (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .svc_valid(svc_valid), .svc_pin(svc_pin),
    .svc_ready(svc_ready), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_rd(logic [7:0] a, logic [3:0] sz);
    int p;
    if (sz != 4'd4) return 32'h0;
    if (a == 8'h00) return {24'h0, m_sel};
    if (a != 8'h10) return 32'h0;
    if (m_sel == 8'h00 || m_sel == 8'h02) return m_id;
    if (m_sel == 8'h01) return 32'h0017_0020;
    if (m_sel >= 8'h10 && m_sel <= 8'h3F) begin
      p = (int'(m_sel) - 16) >> 1;
      return m_sel[0] ? m_tbl[p][63:32] : m_tbl[p][31:0];
    end
    return 32'h0;
  endfunction

  task automatic model_wr(logic [7:0] a, logic [3:0] sz, logic [31:0] d);
    int p;
    if (sz != 4'd4) return;
    if (a == 8'h00) m_sel = d[7:0];
    else if (a == 8'h10) begin
      if (m_sel == 8'h00) m_id = d & 32'h0F00_0000;
      else if (m_sel >= 8'h10 && m_sel <= 8'h3F) begin
        p = (int'(m_sel) - 16) >> 1;
        if (m_sel[0]) m_tbl[p][63:32] = d;
        else          m_tbl[p][31:0]  = d;
      end
    end
  endtask

  function automatic logic [64:0] exp_msg(int pin);
    logic [63:0] e;
    logic [31:0] a, d;
    if (pin >= 24) return 65'h0;
    e = m_tbl[pin];
    a = 32'hFEE0_0000 | {12'h0, e[63:56], e[55:49], 5'b0};
    d = {21'h0, e[10:8], e[7:0]};
    return {(!e[16] && !e[11] && !e[15]), a, d};
  endfunction

  task automatic wr(logic [7:0] a, logic [3:0] sz, logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_size = sz; bus_wdata = d;
    @(posedge clk); #1;
    bus_req = 0; bus_we = 0;
    model_wr(a, sz, d);
  endtask

  task automatic rd(string tag, logic [7:0] a, logic [3:0] sz);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = a; bus_size = sz;
    #1 chk(tag, bus_rdata, model_rd(a, sz));
    bus_req = 0;
  endtask

  task automatic svc(string tag, int pin);
    logic [64:0] e;
    e = exp_msg(pin);
    @(negedge clk);
    chk({tag, " R11 ready"}, {31'h0, svc_ready}, 32'h1);
    svc_valid = 1; svc_pin = 5'(pin);
    @(negedge clk);
    svc_valid = 0;
    #1 chk({tag, " R8 valid"}, {31'h0, msg_valid}, {31'h0, e[64]});
    if (e[64]) begin
      chk({tag, " R9 addr"}, msg_addr, e[63:32]);
      chk({tag, " R10 data"}, msg_data, e[31:0]);
      msg_ready = 1;
      @(negedge clk);
      msg_ready = 0;
      #1 chk({tag, " R11 release"}, {31'h0, msg_valid}, 32'h0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, d0;
    logic [64:0] e;
    void'($urandom(32'd1234));
    rst_n = 0; bus_req = 0; bus_we = 0; bus_addr = 0; bus_size = 4;
    bus_wdata = 0; svc_valid = 0; svc_pin = 0; msg_ready = 0;
    for (int i = 0; i < 24; i++) m_tbl[i] = 64'h0000_0000_0001_0000;
    m_sel = 0; m_id = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);

    // R7 reset state
    #1 chk("R7 svc_ready", {31'h0, svc_ready}, 32'h1);
    chk("R7 msg_valid", {31'h0, msg_valid}, 32'h0);
    rd("R7 sel", 8'h00, 4);
    rd("R7 id", 8'h10, 4);
    wr(8'h00, 4, 32'h10); rd("R7 entry0 lo", 8'h10, 4);
    wr(8'h00, 4, 32'h3F); rd("R7 entry23 hi", 8'h10, 4);
    svc("R7 masked after reset", 5);

    // R4 version, write ignored
    wr(8'h00, 4, 32'h01); wr(8'h10, 4, 32'hFFFF_FFFF);
    rd("R4 version", 8'h10, 4);
    chk("R4 const", model_rd(8'h10, 4), 32'h0017_0020);

    // R3 id field and arbitration alias
    wr(8'h00, 4, 32'h00); wr(8'h10, 4, 32'hFFFF_FFFF);
    rd("R3 id field", 8'h10, 4);
    wr(8'h00, 4, 32'h02); rd("R3 arb alias", 8'h10, 4);
    wr(8'h10, 4, 32'h0000_0000); rd("R3 arb write ignored", 8'h10, 4);

    // R1 narrow accesses
    wr(8'h00, 2, 32'h33); rd("R1 sel unchanged", 8'h00, 4);
    rd("R1 narrow read", 8'h00, 1);
    rd("R1 wide read", 8'h10, 8);

    // R2 other offsets
    wr(8'h04, 4, 32'h55); rd("R2 sel after stray", 8'h00, 4);
    rd("R2 stray read", 8'h14, 4);

    // R6 unknown selects
    wr(8'h00, 4, 32'h07); wr(8'h10, 4, 32'hABCD); rd("R6 sel07", 8'h10, 4);
    wr(8'h00, 4, 32'h40); wr(8'h10, 4, 32'hABCD); rd("R6 sel40", 8'h10, 4);
    wr(8'h00, 4, 32'h02); rd("R6 id untouched", 8'h10, 4);

    // R5 halves independent, pin 23 high half
    wr(8'h00, 4, 32'h3E); wr(8'h10, 4, 32'h0000_0733);
    wr(8'h00, 4, 32'h3F); wr(8'h10, 4, 32'hA5FE_0000);
    rd("R5 hi", 8'h10, 4);
    wr(8'h00, 4, 32'h3E); rd("R5 lo kept", 8'h10, 4);
    svc("R9 R10 pin23", 23);

    // R8 each filter bit and out-of-range pin
    wr(8'h00, 4, 32'h12); wr(8'h10, 4, 32'h0000_0841); svc("R8 logical", 1);
    wr(8'h10, 4, 32'h0000_8041); svc("R8 level", 1);
    wr(8'h10, 4, 32'h0001_0041); svc("R8 mask", 1);
    svc("R8 pin24", 24);
    svc("R8 pin31", 31);

    // R11 hold while not ready, request during hold ignored
    wr(8'h10, 4, 32'h0000_0241);
    e = exp_msg(1);
    @(negedge clk); svc_valid = 1; svc_pin = 1;
    @(negedge clk); svc_pin = 23;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      #1 chk("R11 hold valid", {31'h0, msg_valid}, 32'h1);
      chk("R11 hold addr", msg_addr, e[63:32]);
      chk("R11 hold data", msg_data, e[31:0]);
      chk("R11 busy", {31'h0, svc_ready}, 32'h0);
    end
    msg_ready = 1;
    @(negedge clk); msg_ready = 0; svc_valid = 0;
    #1 chk("R11 no queued request", {31'h0, msg_valid}, 32'h0);

    // R12 write and service in the same cycle
    wr(8'h00, 4, 32'h16); wr(8'h10, 4, 32'h0000_0041);
    e = exp_msg(3);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = 8'h10; bus_size = 4; bus_wdata = 32'h0001_0099;
    svc_valid = 1; svc_pin = 3;
    @(negedge clk);
    bus_req = 0; bus_we = 0; svc_valid = 0;
    model_wr(8'h10, 4, 32'h0001_0099);
    #1 chk("R12 valid", {31'h0, msg_valid}, 32'h1);
    chk("R12 old data", msg_data, e[31:0]);
    msg_ready = 1; @(negedge clk); msg_ready = 0;
    rd("R12 new entry", 8'h10, 4);
    svc("R12 now masked", 3);

    // random mix, R5 R8 R9 R10
    for (int it = 0; it < 250; it++) begin
      v = $urandom;
      if ($urandom % 2 != 0) v = v & ~32'h0001_8800;
      d0 = 32'($urandom % 72);
      wr(8'h00, 4, d0);
      wr(8'h10, ($urandom % 5 == 0) ? 4'd2 : 4'd4, v);
      rd("R5 rnd readback", 8'h10, 4);
      if ($urandom % 4 == 0) wr(($urandom % 2 != 0) ? 8'h10 : 8'h00, 4, $urandom);
      svc("R8 rnd service", int'($urandom % 26));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule